// File: doc/BRIEF.md
# Serial Flash Frame Sequencer

This block issues a single serial flash command frame on a one-bit SPI bus under register control. Software first loads a command byte, an address word, a phase-select word, a dummy-clock count and a 32-bit outgoing data word through a small word-addressed register port. It then writes the control register with its go bit set. The engine lowers chip select, runs SCK in SPI mode 0 and shifts out the enabled phases, always in this order: command, address, dummy clocks, data. When the frame is complete it sets a completion flag.

A frame may be told to leave chip select asserted when it ends. The next frame then continues the same flash transaction. Software normally clears the command and address selects for these follow-on frames, so that a long write streams out one data word per frame with no break in chip select.

The frame is captured when the go bit is accepted. Register writes made while the frame runs therefore change only the next frame. SCK runs at the system clock divided by 2*DIV.

Top module: `sflash_seq`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, mosi is 0 and the status word (register 6) reads 0.
- R2: Registers 1 (command byte in bits 23:16), 2 (address, 32 bits), 3 (phase select: bit 15 dummy enable, bit 14 command enable, bits 11:8 address lanes, bits 3:0 data lanes), 4 (dummy count minus one, low 4 bits) and 5 (data word) read back the values last written. Bits they do not implement read as 0.
- R3: The engine uses SPI mode 0 and sends every phase MSB first. SCK idles low, and mosi never changes while SCK is high. When bit 14 of register 3 is set, the frame begins with the command byte.
- R4: The address-lane field sets the number of address bytes by its highest set bit. 0xF sends all 4 bytes of register 2, 0x7 sends its low 3 bytes, and 0 sends no address.
- R5: When bit 15 of register 3 is set, the engine inserts (register 4 + 1) SCK clocks with mosi held at 0 between the address and the data.
- R6: The data phase runs only when the go write also sets bit 1 of register 0 and the data-lane field is nonzero. A field of 0xF shifts out all 32 bits of register 5.
- R7: Any phase that is disabled is left out entirely. The number of SCK rising edges equals the number of bits in the frame, and a frame with nothing enabled produces no SCK edges.
- R8: Status bit 0 is set when a frame finishes. Writing register 0 with bit 0 set, while the engine is idle, starts a frame and clears this flag.
- R9: Setting bit 8 of register 0 together with go keeps cs_n low after the frame ends, and status bit 1 then stays 1. The following frames continue with no cs_n rise. A frame started without bit 8 releases cs_n at its end, and status bit 1 then reads 0.
- R10: A go write made while a frame is in progress has no effect. The running frame goes out unchanged, its keep-select setting is not replaced, and no second frame follows.
- R11: One SCK period lasts 2*DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word index for writes |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register word index for reads |
| rd_data | output | 32 | Register read data (combinational) |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |

## Verification
The bench varies the address-lane field over 0, 0x7, 0xF and other values, and it includes frames with every phase disabled. A design with the wrong lane decode or the wrong phase order would send a bit stream of the wrong length or in the wrong sequence. In a chained transaction of three frames, the bench checks that cs_n never rises between frames and that it rises exactly once at the end; a lost keep-select would show up as an early release. It also issues a go write with a new command and the keep-select bit while a frame is running. The running frame must go out unchanged, cs_n must still be released at its end, and no second frame may appear. A mistimed SCK divider is caught by measuring the SCK period, and a mode-0 error is caught if mosi changes while SCK is high.

// File: rtl/sflash_seq.sv
module sflash_seq #(
  parameter int DIV     = 2,
  parameter int DUMMY_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        sck,
  output logic        cs_n,
  output logic        mosi
);
  localparam int FRAME_W = 8 + 32 + (1 << DUMMY_W) + 32;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int DIV_W   = (DIV > 1) ? $clog2(DIV) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_END} state_t;

  state_t              state;
  logic [7:0]          cmd_q;
  logic [31:0]         addr_q;
  logic [31:0]         wdat_q;
  logic [DUMMY_W-1:0]  dum_q;
  logic                cmd_en, dum_en;
  logic [3:0]          addr_m, data_m;
  logic [FRAME_W-1:0]  sh, fv;
  logic [CNT_W-1:0]    bits, flen;
  logic [DIV_W-1:0]    div;
  logic                keep_q, done_q;
  logic                start_req, accept;

  assign start_req = wr_en && wr_addr == 3'd0 && wr_data[0];
  assign accept    = start_req && state == S_IDLE;
  assign mosi      = (state == S_RUN) && sh[FRAME_W-1];

  function automatic int lanes(input logic [3:0] m);
    if (m[3]) return 4;
    if (m[2]) return 3;
    if (m[1]) return 2;
    if (m[0]) return 1;
    return 0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; addr_q <= '0; wdat_q <= '0; dum_q <= '0;
      cmd_en <= 1'b0; dum_en <= 1'b0; addr_m <= '0; data_m <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd1: cmd_q  <= wr_data[23:16];
        3'd2: addr_q <= wr_data;
        3'd3: begin
          dum_en <= wr_data[15];
          cmd_en <= wr_data[14];
          addr_m <= wr_data[11:8];
          data_m <= wr_data[3:0];
        end
        3'd4: dum_q  <= wr_data[DUMMY_W-1:0];
        3'd5: wdat_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    fv   = '0;
    flen = '0;
    if (cmd_en) begin
      fv   = {fv[FRAME_W-9:0], cmd_q};
      flen = flen + CNT_W'(8);
    end
    for (int i = 3; i >= 0; i--) begin
      if (i < lanes(addr_m)) begin
        fv   = {fv[FRAME_W-9:0], addr_q[8*i +: 8]};
        flen = flen + CNT_W'(8);
      end
    end
    if (dum_en) begin
      fv   = fv << (int'(dum_q) + 1);
      flen = flen + CNT_W'(int'(dum_q) + 1);
    end
    if (wr_data[1]) begin
      for (int i = 3; i >= 0; i--) begin
        if (i < lanes(data_m)) begin
          fv   = {fv[FRAME_W-9:0], wdat_q[8*i +: 8]};
          flen = flen + CNT_W'(8);
        end
      end
    end
    fv = fv << (FRAME_W - int'(flen));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sh     <= '0;
      bits   <= '0;
      div    <= '0;
      sck    <= 1'b0;
      cs_n   <= 1'b1;
      keep_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          sh     <= fv;
          bits   <= flen;
          keep_q <= wr_data[8];
          done_q <= 1'b0;
          cs_n   <= 1'b0;
          div    <= '0;
          state  <= (flen == '0) ? S_END : S_RUN;
        end
        S_RUN: begin
          if (div == DIV_W'(DIV - 1)) begin
            div <= '0;
            if (!sck) begin
              sck <= 1'b1;
            end else begin
              sck  <= 1'b0;
              sh   <= sh << 1;
              bits <= bits - CNT_W'(1);
              if (bits == CNT_W'(1)) state <= S_END;
            end
          end else begin
            div <= div + DIV_W'(1);
          end
        end
        default: begin
          done_q <= 1'b1;
          cs_n   <= ~keep_q;
          state  <= S_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      3'd1:    rd_data = {8'h0, cmd_q, 16'h0};
      3'd2:    rd_data = addr_q;
      3'd3:    rd_data = {16'h0, dum_en, cmd_en, 2'b0, addr_m, 4'b0, data_m};
      3'd4:    rd_data = 32'(dum_q);
      3'd5:    rd_data = wdat_q;
      3'd6:    rd_data = {30'h0, ~cs_n, done_q};
      default: rd_data = '0;
    endcase
  end

  AST_MODE0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi)); // R3
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_RUN) |-> !sck); // R3
  AST_CS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN) |-> !cs_n); // R9
  AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (cs_n == !keep_q)); // R9
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !done_q); // R8
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && state == S_RUN) |=> ($stable(keep_q) && state != S_IDLE)); // R10
endmodule

// File: tb/sflash_seq_bench.sv
module sflash_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic sck, cs_n, mosi;

  sflash_seq u_sflash_seq (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sck(sck), .cs_n(cs_n), .mosi(mosi));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit cap [0:511];
  bit expb [0:511];
  int ncap = 0, nexp = 0, cs_rises = 0, mode_err = 0, nrise = 0;
  time t0 = 0, t1 = 0;
  logic psck = 1'b0, pmosi = 1'b0;

  always @(posedge sck) if (!cs_n) begin
    if (ncap < 512) cap[ncap] = mosi;
    ncap++;
    if (nrise == 0) t0 = $time; else if (nrise == 1) t1 = $time;
    nrise++;
  end
  always @(posedge cs_n) cs_rises++;
  always @(negedge clk) begin
    if (sck && psck && mosi !== pmosi) mode_err++;
    psck = sck; pmosi = mosi;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  function automatic int lanes(input logic [3:0] m);
    return m[3] ? 4 : m[2] ? 3 : m[1] ? 2 : m[0] ? 1 : 0;
  endfunction

  task automatic push(input bit b);
    expb[nexp] = b; nexp++;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int k = 0; k < 3000; k++) begin
      rd(3'd6, s);
      if (s[0]) return;
    end
    chk(1'b0, "R8 done timeout", 0, 1);
  endtask

  task automatic frame(input bit ce, input logic [7:0] c, input logic [3:0] am,
                       input logic [31:0] a, input bit de, input logic [3:0] d,
                       input logic [3:0] dm, input logic [31:0] w, input bit wrb,
                       input bit keep, input bit append, input bit wait_end);
    wr(3'd1, {8'h0, c, 16'h0});
    wr(3'd2, a);
    wr(3'd3, {16'h0, de, ce, 2'b0, am, 4'b0, dm});
    wr(3'd4, {28'h0, d});
    wr(3'd5, w);
    if (!append) begin ncap = 0; nexp = 0; end
    if (ce) for (int b = 7; b >= 0; b--) push(c[b]);
    for (int b = lanes(am) * 8 - 1; b >= 0; b--) push(a[b]);
    if (de) for (int b = 0; b <= int'(d); b++) push(1'b0);
    if (wrb) for (int b = lanes(dm) * 8 - 1; b >= 0; b--) push(w[b]);
    wr(3'd0, {23'h0, keep, 6'h0, wrb, 1'b1});
    if (wait_end) wait_done();
  endtask

  task automatic compare(input string req);
    int bad = 0;
    chk(ncap == nexp, {req, " bit count"}, ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++) if (cap[i] != expb[i]) bad++;
    chk(bad == 0, {req, " bit stream mismatches"}, bad, 0);
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] s;
    int r0;
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd6, s);
    chk(cs_n == 1 && sck == 0 && mosi == 0, "R1 pins after reset", {cs_n, sck, mosi}, 3'b100);
    chk(s == 0, "R1 status after reset", s, 0);

    wr(3'd1, 32'hFFA5FFFF); rd(3'd1, s); chk(s == 32'h00A50000, "R2 command reg", s, 32'h00A50000);
    wr(3'd2, 32'h12345678); rd(3'd2, s); chk(s == 32'h12345678, "R2 address reg", s, 32'h12345678);
    wr(3'd3, 32'hFFFFFFFF); rd(3'd3, s); chk(s == 32'h0000CF0F, "R2 phase reg", s, 32'h0000CF0F);
    wr(3'd4, 32'hFFFFFFF9); rd(3'd4, s); chk(s == 32'h9, "R2 dummy reg", s, 9);
    wr(3'd5, 32'hCAFEF00D); rd(3'd5, s); chk(s == 32'hCAFEF00D, "R2 data reg", s, 32'hCAFEF00D);

    // R3 command only, plus SCK period check R11
    nrise = 0;
    frame(1, 8'h9F, 4'h0, 0, 0, 0, 4'h0, 0, 0, 0, 0, 1);
    compare("R3 command only");
    chk(t1 - t0 == 16, "R11 sck period ns", t1 - t0, 16);

    frame(1, 8'h0B, 4'hF, 32'hA1B2C3D4, 1, 4'd7, 4'hF, 32'h8001_7FFE, 1, 0, 0, 1);
    compare("R4 R5 R6 full frame 4-byte address");
    frame(1, 8'h03, 4'h7, 32'hEE112233, 0, 0, 4'hF, 32'h5555AAAA, 0, 0, 0, 1);
    compare("R4 3-byte address, R6 data off without write bit");
    frame(0, 8'h00, 4'h0, 0, 1, 4'd0, 4'hF, 32'hDEADBEEF, 1, 0, 0, 1);
    compare("R5 R6 single dummy then data");
    frame(0, 8'hFF, 4'h0, 32'hFFFFFFFF, 0, 4'd3, 4'h0, 32'hFFFFFFFF, 1, 0, 0, 1);
    compare("R7 empty frame");
    rd(3'd6, s);
    chk(s == 32'h1, "R7 empty frame completes and releases", s, 1);

    for (int n = 0; n < 25; n++) begin
      logic [3:0] am, dm;
      r0 = int'($urandom % 4);
      am = (r0 == 0) ? 4'h0 : (r0 == 1) ? 4'h7 : (r0 == 2) ? 4'hF : 4'($urandom);
      r0 = int'($urandom % 3);
      dm = (r0 == 0) ? 4'hF : 4'($urandom);
      frame(1'($urandom), 8'($urandom), am, $urandom, 1'($urandom), 4'($urandom),
            dm, $urandom, 1'($urandom), 0, 0, 1);
      compare("R7 random frame");
    end

    // R8 done cleared by start
    frame(1, 8'h02, 4'hF, 32'h1, 0, 0, 4'hF, 32'h2, 1, 0, 0, 0);
    rd(3'd6, s);
    chk(s == 32'h2, "R8 done cleared at start, select active", s, 2);
    wait_done();
    rd(3'd6, s);
    chk(s == 32'h1, "R8 done set after frame", s, 1);

    // R9 chained transaction
    cs_rises = 0;
    frame(1, 8'h02, 4'h7, 32'h00ABCDEF, 0, 0, 4'h0, 0, 0, 1, 0, 1);
    rd(3'd6, s);
    chk(cs_n == 0 && s == 32'h3, "R9 select held after keep frame", s, 3);
    frame(0, 8'h00, 4'h0, 0, 0, 0, 4'hF, 32'h01234567, 1, 1, 1, 1);
    frame(0, 8'h00, 4'h0, 0, 0, 0, 4'hF, 32'h89ABCDEF, 1, 0, 1, 1);
    compare("R9 chained stream");
    rd(3'd6, s);
    chk(cs_rises == 1, "R9 single cs release", cs_rises, 1);
    chk(s == 32'h1, "R9 select flag clear after release", s, 1);

    // R10 go while busy ignored
    frame(1, 8'h38, 4'hF, 32'h0F0F0F0F, 0, 0, 4'hF, 32'h12345678, 1, 0, 0, 0);
    repeat (20) @(negedge clk);
    wr(3'd1, 32'h00C70000);
    wr(3'd0, 32'h00000103);
    wait_done();
    compare("R10 running frame unchanged");
    chk(cs_n == 1, "R10 keep from ignored write not applied", cs_n, 1);
    r0 = ncap;
    repeat (200) @(negedge clk);
    chk(ncap == r0, "R10 no second frame", ncap, r0);

    chk(mode_err == 0, "R3 mosi stable while sck high", mode_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule